// File: doc/BRIEF.md
# Register-Mapped Stream FIFO Bridge

This block joins a simple register bus to the streaming channels of a serial-bus engine through three first-in first-out buffers. Software writes commands and outgoing data words into two of the buffers, and each of these drains into a valid/ready output stream. Incoming data words arrive on a valid/ready input stream, fill the third buffer, and are taken out by register reads. Software can read how much room is left in the two transmit-side buffers, how many words wait in the receive buffer, and the head receive word without removing it.

A two-state control machine gates the whole block. In `ST_OFF` all three buffers are held empty and every stream handshake output is low. Writing 1 to the control register in `ST_OFF` takes the "arm" transition to `ST_ON`. Writing 0 in `ST_ON` takes the "drop" transition back to `ST_OFF`, and the buffers are flushed at that same clock edge. Each buffer depth is a power of two set by its own address-width parameter. Register reads are registered: the value of a read appears on `bus_rdata` one cycle after the strobe.

Top module: `stream_fifo_bridge`

## Requirements
- R1: After reset the block is in `ST_OFF`, `bus_rdata` is 0, and `cmd_valid`, `txd_valid` and `rxd_ready` are low.
- R2: Words written to offset 1 (command) and offset 2 (outgoing data) leave on `cmd_data` / `txd_data` in write order. A word moves only in a cycle where both valid and ready are high. Valid is high whenever the block is on and the buffer is not empty.
- R3: A write to a full command or outgoing-data buffer is discarded, and the buffer is unchanged. This holds even when the stream drains an entry in the same cycle, because fullness is judged before that cycle's edge.
- R4: Reading offset 3 returns the free entries of the command buffer (2^CMD_AW minus its count). Reading offset 4 does the same for the outgoing-data buffer.
- R5: `rxd_ready` is high exactly when the block is on and the receive buffer is not full. An incoming word is stored when `rxd_valid` and `rxd_ready` are both high.
- R6: Reading offset 5 returns the head receive word and removes it. A read at offset 5 when the buffer is empty leaves the buffer empty.
- R7: Reading offset 6 returns the head receive word and leaves the buffer count unchanged.
- R8: Reading offset 7 returns the number of words held in the receive buffer.
- R9: Offset 0 bit 0 is the enable and reads back as the current state (1 = `ST_ON`). Writing 0 empties all three buffers at that edge. While off, pushes are dropped, `cmd_valid`, `txd_valid` and `rxd_ready` stay low, and the buffers stay empty.
- R10: `bus_rdata` changes only on the clock edge that ends a cycle with `bus_rd` high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | CMD_W | Command stream word |
| txd_valid | output | 1 | Outgoing data stream valid |
| txd_ready | input | 1 | Outgoing data stream ready |
| txd_data | output | DAT_W | Outgoing data word |
| rxd_valid | input | 1 | Incoming data stream valid |
| rxd_ready | output | 1 | Incoming data stream ready |
| rxd_data | input | DAT_W | Incoming data word |

## Verification
Two pairs of events can share one cycle. In the first, a bus push meets a stream drain on a full transmit-side buffer. In the second, a bus pop or peek meets a stream push into the receive buffer. The directed phase forces both: it fills a buffer with ready low, then writes once more while ready is high, and it pops while `rxd_valid` is high. The random phase then overlaps these events freely. A queue model in the bench settles each push or pop from the counts held before the edge, and it judges every stream word and every read value against those counts.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        RA_CTRL     = 3'd0,
        RA_CMD_PUSH = 3'd1,
        RA_TX_PUSH  = 3'd2,
        RA_CMD_ROOM = 3'd3,
        RA_TX_ROOM  = 3'd4,
        RA_RX_POP   = 3'd5,
        RA_RX_PEEK  = 3'd6,
        RA_RX_LEVEL = 3'd7
    } reg_addr_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } en_state_e;
endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
    parameter int AW = 3,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdat,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [AW:0]   level,
    output logic [AW:0]   room,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign level   = wp - rp;
    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign room    = CW'(DEPTH) - level;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= wdat;
    end
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic drop_req,
    output logic en_on,
    output logic flush
);
    en_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (arm_req)  state_nx = ST_ON;
            ST_ON:  if (drop_req) state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        en_on = 1'b0;
        flush = 1'b1;
        unique case (state)
            ST_OFF: begin
                en_on = 1'b0;
                flush = 1'b1;
            end
            ST_ON: begin
                en_on = 1'b1;
                flush = drop_req;
            end
        endcase
    end
endmodule

// File: rtl/sfb_regs.sv
module sfb_regs
    import sfb_pkg::*;
#(
    parameter int CMD_AW = 3,
    parameter int TX_AW  = 2,
    parameter int RX_AW  = 3,
    parameter int DAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              en_on,
    input  logic [CMD_AW:0]   cmd_room,
    input  logic [TX_AW:0]    tx_room,
    input  logic [RX_AW:0]    rx_level,
    input  logic [DAT_W-1:0]  rx_head,
    output logic              cmd_push,
    output logic              tx_push,
    output logic              rx_pop,
    output logic              arm_req,
    output logic              drop_req,
    output logic [BUS_W-1:0]  bus_rdata
);
    reg_addr_e          ra;
    logic [BUS_W-1:0]   rd_mux;

    assign ra       = reg_addr_e'(bus_addr);
    assign cmd_push = bus_wr && (ra == RA_CMD_PUSH);
    assign tx_push  = bus_wr && (ra == RA_TX_PUSH);
    assign arm_req  = bus_wr && (ra == RA_CTRL) &&  bus_wdata[0];
    assign drop_req = bus_wr && (ra == RA_CTRL) && !bus_wdata[0];
    assign rx_pop   = bus_rd && (ra == RA_RX_POP);

    always_comb begin
        rd_mux = '0;
        unique case (ra)
            RA_CTRL:     rd_mux = BUS_W'(en_on);
            RA_CMD_ROOM: rd_mux = BUS_W'(cmd_room);
            RA_TX_ROOM:  rd_mux = BUS_W'(tx_room);
            RA_RX_POP:   rd_mux = BUS_W'(rx_head);
            RA_RX_PEEK:  rd_mux = BUS_W'(rx_head);
            RA_RX_LEVEL: rd_mux = BUS_W'(rx_level);
            RA_CMD_PUSH,
            RA_TX_PUSH:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/stream_fifo_bridge.sv
module stream_fifo_bridge
    import sfb_pkg::*;
#(
    parameter int CMD_AW = 3,
    parameter int TX_AW  = 2,
    parameter int RX_AW  = 3,
    parameter int CMD_W  = 16,
    parameter int DAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              txd_valid,
    input  logic              txd_ready,
    output logic [DAT_W-1:0]  txd_data,
    input  logic              rxd_valid,
    output logic              rxd_ready,
    input  logic [DAT_W-1:0]  rxd_data
);
    logic              en_on, flush;
    logic              arm_req, drop_req;
    logic              cmd_push, tx_push, rx_pop;
    logic [CMD_AW:0]   cmd_level, cmd_room;
    logic [TX_AW:0]    tx_level, tx_room;
    logic [RX_AW:0]    rx_level, rx_room;
    logic              cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
    logic [DAT_W-1:0]  rx_head;

    sfb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_req  (arm_req),
        .drop_req (drop_req),
        .en_on    (en_on),
        .flush    (flush)
    );

    sfb_regs #(
        .CMD_AW (CMD_AW),
        .TX_AW  (TX_AW),
        .RX_AW  (RX_AW),
        .DAT_W  (DAT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_on     (en_on),
        .cmd_room  (cmd_room),
        .tx_room   (tx_room),
        .rx_level  (rx_level),
        .rx_head   (rx_head),
        .cmd_push  (cmd_push),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop),
        .arm_req   (arm_req),
        .drop_req  (drop_req),
        .bus_rdata (bus_rdata)
    );

    assign cmd_valid = en_on && !cmd_empty;
    assign txd_valid = en_on && !tx_empty;
    assign rxd_ready = en_on && !rx_full;

    sfb_fifo #(.AW(CMD_AW), .W(CMD_W)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (cmd_push && en_on),
        .wdat  (bus_wdata[CMD_W-1:0]),
        .pop   (cmd_valid && cmd_ready),
        .head  (cmd_data),
        .level (cmd_level),
        .room  (cmd_room),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    sfb_fifo #(.AW(TX_AW), .W(DAT_W)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (tx_push && en_on),
        .wdat  (bus_wdata[DAT_W-1:0]),
        .pop   (txd_valid && txd_ready),
        .head  (txd_data),
        .level (tx_level),
        .room  (tx_room),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfb_fifo #(.AW(RX_AW), .W(DAT_W)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (rxd_valid && rxd_ready),
        .wdat  (rxd_data),
        .pop   (rx_pop && en_on),
        .head  (rx_head),
        .level (rx_level),
        .room  (rx_room),
        .full  (rx_full),
        .empty (rx_empty)
    );
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker
    import sfb_pkg::*;
#(
    parameter int CMD_AW = 3,
    parameter int RX_AW  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [2:0]      bus_addr,
    input logic [31:0]     bus_rdata,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            txd_valid,
    input logic            rxd_valid,
    input logic            rxd_ready,
    input logic [CMD_AW:0] cmd_room,
    input logic [RX_AW:0]  rx_level,
    input logic            en_on
);
    localparam int RXD = 1 << RX_AW;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && cmd_room == '0 && bus_wr && bus_addr == RA_CMD_PUSH && !(cmd_valid && cmd_ready))
        |=> (cmd_room == '0));

    a_r5_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == (RX_AW+1)'(RXD)) |-> !rxd_ready);

    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0 && bus_rd && bus_addr == RA_RX_POP && !(rxd_valid && rxd_ready))
        |=> (rx_level == '0));

    a_r7_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == RA_RX_PEEK && !bus_wr && !(rxd_valid && rxd_ready))
        |=> $stable(rx_level));

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_on |-> (!cmd_valid && !txd_valid && !rxd_ready && rx_level == '0));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind stream_fifo_bridge sfb_checker #(
    .CMD_AW (CMD_AW),
    .RX_AW  (RX_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .txd_valid (txd_valid),
    .rxd_valid (rxd_valid),
    .rxd_ready (rxd_ready),
    .cmd_room  (cmd_room),
    .rx_level  (rx_level),
    .en_on     (en_on)
);

// File: tb/sim_stream_fifo_bridge.sv
`timescale 1ns/1ps
module sim_stream_fifo_bridge;
    localparam int CMD_AW = 3, TX_AW = 2, RX_AW = 3, CMD_W = 16, DAT_W = 8;
    localparam int CD = 1 << CMD_AW, TD = 1 << TX_AW, RD = 1 << RX_AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic cmd_valid, cmd_ready = 0, txd_valid, txd_ready = 0, rxd_valid = 0, rxd_ready;
    logic [CMD_W-1:0] cmd_data;
    logic [DAT_W-1:0] txd_data, rxd_data = '0;

    always #2 clk = ~clk;

    stream_fifo_bridge #(.CMD_AW(CMD_AW), .TX_AW(TX_AW), .RX_AW(RX_AW),
                         .CMD_W(CMD_W), .DAT_W(DAT_W)) u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [CMD_W-1:0] q_cmd[$];
    logic [DAT_W-1:0] q_tx[$], q_rx[$];
    bit en_m = 0;
    int pend = 0;              // 0 none, 1 check value, 2 skip
    string pend_tag;
    logic [31:0] exp_rd, last_rd;
    bit c_rdy = 0, t_rdy = 0, r_vld = 0;
    logic [DAT_W-1:0] r_dat = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R9";
            3'd3, 3'd4: return "R4";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // one bus cycle plus stream activity; model settles from pre-edge counts
    task automatic step(input bit w, input bit r, input logic [2:0] a,
                        input logic [31:0] d, input string tg);
        bit cpop, tpop, rpush, acc;
        @(negedge clk);
        if (pend == 1) chk(pend_tag, bus_rdata, exp_rd);
        else if (pend == 0) chk("R10", bus_rdata, last_rd);
        last_rd = bus_rdata;
        pend = 0;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        cmd_ready = c_rdy; txd_ready = t_rdy; rxd_valid = r_vld; rxd_data = r_dat;
        #1;
        chk(en_m ? "R2" : "R9", {31'b0, cmd_valid}, {31'b0, en_m && q_cmd.size() > 0});
        chk(en_m ? "R2" : "R9", {31'b0, txd_valid}, {31'b0, en_m && q_tx.size() > 0});
        chk("R5", {31'b0, rxd_ready}, {31'b0, en_m && q_rx.size() < RD});
        cpop = cmd_valid && cmd_ready;
        tpop = txd_valid && txd_ready;
        rpush = rxd_valid && rxd_ready;
        if (cpop && q_cmd.size() > 0) chk("R2", 32'(cmd_data), 32'(q_cmd[0]));
        if (tpop && q_tx.size() > 0) chk("R2", 32'(txd_data), 32'(q_tx[0]));
        if (r) begin
            pend = 1;
            pend_tag = (tg == "") ? tag_of(a) : tg;
            case (a)
                3'd0: exp_rd = {31'b0, en_m};
                3'd3: exp_rd = 32'(CD - q_cmd.size());
                3'd4: exp_rd = 32'(TD - q_tx.size());
                3'd5, 3'd6: if (q_rx.size() > 0) exp_rd = 32'(q_rx[0]); else pend = 2;
                3'd7: exp_rd = 32'(q_rx.size());
                default: exp_rd = 0;
            endcase
        end
        // transmit-side updates: acceptance judged before the drain
        acc = w && a == 3'd1 && en_m && q_cmd.size() < CD;
        if (cpop) void'(q_cmd.pop_front());
        if (acc) q_cmd.push_back(d[CMD_W-1:0]);
        acc = w && a == 3'd2 && en_m && q_tx.size() < TD;
        if (tpop) void'(q_tx.pop_front());
        if (acc) q_tx.push_back(d[DAT_W-1:0]);
        acc = r && a == 3'd5 && en_m && q_rx.size() > 0;
        if (acc) void'(q_rx.pop_front());
        if (rpush) q_rx.push_back(rxd_data);
        if (w && a == 3'd0) begin
            if (d[0]) en_m = 1;
            else begin en_m = 0; q_cmd.delete(); q_tx.delete(); q_rx.delete(); end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 0, "");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", bus_rdata, 0);
        chk("R1", {29'b0, cmd_valid, txd_valid, rxd_ready}, 0);
        rst_n = 1'b1;
        last_rd = 0;
        step(0, 1, 3'd0, 0, "R1");            // enable reads 0 after reset
        step(0, 1, 3'd7, 0, "");
        step(1, 0, 3'd1, 32'h11, "");         // R9: dropped while off
        step(1, 0, 3'd0, 1, "");              // arm
        step(0, 1, 3'd3, 0, "");              // R4: full room
        step(0, 1, 3'd0, 0, "");
        // R3: outgoing buffer overflow with ready low
        for (int i = 0; i < TD + 1; i++) step(1, 0, 3'd2, 32'(8'h40 + i), "");
        step(0, 1, 3'd4, 0, "R3");
        t_rdy = 1; idle(TD + 1); t_rdy = 0;
        // R3: command buffer full, push coincides with a drain
        for (int i = 0; i < CD; i++) step(1, 0, 3'd1, 32'(16'hA000 + i), "");
        c_rdy = 1;
        step(1, 0, 3'd1, 32'hBEEF, "R3");
        c_rdy = 0;
        step(0, 1, 3'd3, 0, "R3");
        c_rdy = 1; idle(CD); c_rdy = 0;
        // receive path: R5 R6 R7 R8
        r_vld = 1;
        for (int i = 0; i < 3; i++) begin r_dat = 8'h70 + 8'(i); step(0, 0, 3'd0, 0, ""); end
        r_vld = 0;
        step(0, 1, 3'd6, 0, "");
        step(0, 1, 3'd6, 0, "");
        step(0, 1, 3'd7, 0, "");
        r_vld = 1; r_dat = 8'h99;
        step(0, 1, 3'd5, 0, "");              // pop meets push
        r_vld = 0;
        for (int i = 0; i < 4; i++) step(0, 1, 3'd5, 0, "");
        step(0, 1, 3'd7, 0, "R6");
        r_vld = 1;
        for (int i = 0; i < RD + 2; i++) begin r_dat = 8'(i * 3); step(0, 0, 3'd0, 0, ""); end
        r_vld = 0;
        step(0, 1, 3'd7, 0, "R5");
        // R9: drop flushes everything
        step(1, 0, 3'd1, 32'h1234, "");
        step(1, 0, 3'd0, 0, "");
        step(0, 1, 3'd7, 0, "R9");
        step(0, 1, 3'd3, 0, "R9");
        step(1, 0, 3'd1, 1, "");
        step(0, 1, 3'd3, 0, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] rd32;
            c_rdy = ($urandom % 3) != 0;
            t_rdy = ($urandom % 3) != 0;
            r_vld = ($urandom % 2) != 0;
            r_dat = 8'($urandom);
            rd32 = $urandom;
            op = $urandom % 100;
            if (op < 2) step(1, 0, 3'd0, {31'b0, 1'b0}, "");
            else if (op < 6) step(1, 0, 3'd0, 1, "");
            else if (op < 30) step(1, 0, 3'd1, rd32, "");
            else if (op < 50) step(1, 0, 3'd2, rd32, "");
            else if (op < 90) step(0, 1, 3'(3 + $urandom % 5), 0, "");
            else step(0, 0, 3'd0, 0, "");
        end
        step(0, 0, 3'd0, 0, "");
        finish_run();
    end
endmodule